// File: doc/BRIEF.md
# Synchronous serial receive controller

This block is the receive side of a four-wire synchronous serial port. It works either as clock master, generating the serial clock and a chip-select and sampling the data line driven by the remote device, or as a slave that takes an external clock and accepts bits only while its chip-select input is held low. Bits arrive most significant first. When a frame of the programmed length (8 to 16 bits) is complete, the word is placed right-aligned in a holding register and a data-ready flag rises. An interrupt output can be enabled for both data-ready and overrun.

As master the engine does not run on its own. A read strobe on the holding register starts a frame, so the first read is a dummy read that launches reception. With the single-frame control set, the clock stops cleanly after the current frame. With it clear and reception enabled, frames follow back to back. A frame that completes while the previous word has not been read is an overrun. An overrun keeps the old word, stops the clock and blocks all reception until software clears the error.

Clock polarity sets the idle level of the clock. Clock phase selects whether data is sampled on the leading edge or the trailing edge of each bit. The master clock half-period is a fixed parameter. The slave pins pass through a two-stage synchronizer before edge detection.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, rx_ready, rx_overrun and rx_irq are 0, rd_data is 0, cs_n_o is 1 and sck_o equals cfg_cpol.
- R2: In master mode, a rd_strobe pulse while cfg_rx_en is 1, rx_overrun is 0 and the engine is idle starts a frame. cs_n_o goes low and sck_o toggles every HALF_DIV clocks, starting from and returning to the idle level cfg_cpol.
- R3: The frame length is cfg_frame_len limited to the range MIN_LEN..MAX_LEN (8..16 by default). Bits are shifted in MSB first, and the word sits right-aligned in rd_data with the unused upper bits 0.
- R4: With cfg_cpha = 0, data is sampled on the leading edge (away from idle). With cfg_cpha = 1, it is sampled on the trailing edge (back to idle). rx_ready rises at the clock edge of the last sampling edge of the frame. With cfg_cpha = 0 this happens while the master clock is still at its active level, inside the last bit period.
- R5: A rd_strobe clears rx_ready, unless a frame completes in the same cycle. In that case the new word loads and rx_ready stays 1.
- R6: With cfg_stop_one = 1, the master stops after the current frame: sck_o returns to idle, cs_n_o goes high and no further frame starts without another read. With cfg_stop_one = 0 and cfg_rx_en = 1, the next frame starts right away.
- R7: A frame completing while rx_ready is 1 (with no read in that cycle) sets rx_overrun. rd_data keeps the earlier word and the master clock stops.
- R8: While rx_overrun is 1, rd_strobe starts no clock and slave clock edges are ignored. An ovr_clr pulse clears rx_overrun, after which reception can start again.
- R9: rx_irq equals cfg_irq_en AND (rx_ready OR rx_overrun).
- R10: In slave mode (cfg_master = 0, cfg_rx_en = 1), bits are taken from mosi_i on the synchronized sck_i edges only while the synchronized cs_n_i is low. Edges while cs_n_i is high are ignored, and cs_n_i high discards a partial frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = clock master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = on trailing edge |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_stop_one | input | 1 | Master stops after the current frame |
| cfg_irq_en | input | 1 | Enables rx_irq for ready and overrun |
| cfg_frame_len | input | LEN_W | Requested frame length in bits |
| rd_strobe | input | 1 | One-cycle read of the receive register |
| ovr_clr | input | 1 | One-cycle clear of the overrun flag |
| rd_data | output | MAX_LEN | Received word, right-aligned |
| rx_ready | output | 1 | Data-ready flag |
| rx_overrun | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive/overrun interrupt request |
| sck_o | output | 1 | Master serial clock |
| cs_n_o | output | 1 | Master chip-select, low during a frame |
| miso_i | input | 1 | Master-mode serial data input |
| sck_i | input | 1 | Slave-mode serial clock input |
| cs_n_i | input | 1 | Slave-mode chip-select input, active low |
| mosi_i | input | 1 | Slave-mode serial data input |

## Verification
The bench uses the default parameters with HALF_DIV = 2, MIN_LEN = 8 and MAX_LEN = 16. The short half-period makes an 8-bit master frame take 32 clocks. That keeps back-to-back frames, overrun on the second unread frame and mid-stream stop requests cheap to reach, and the reply model stays exact on every edge. A 5-bit length field covers requests below 8 and above 16, so both ends of the length clamp are driven. All four polarity/phase combinations are used in master mode, and slave mode is driven with a half-period long enough to clear the synchronizer latency.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } mst_state_e;

  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen
  import srx_pkg::*;
#(
  parameter  int HALF_DIV = 2,
  parameter  int MAX_LEN  = 16,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int DIV_W    = $clog2(HALF_DIV + 1),
  localparam int EDGE_W   = $clog2(2 * MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic             keep_going,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] len,
  output logic             sck,
  output logic             busy,
  output logic             sample
);

  mst_state_e          state_q, state_d;
  logic [DIV_W-1:0]    div_q, div_d;
  logic [EDGE_W-1:0]   edge_q, edge_d;
  logic                phase_q, phase_d;
  logic                tick, last_tgl;
  logic [EDGE_W-1:0]   last_idx;

  always_comb begin
    last_idx = EDGE_W'({len, 1'b0}) - EDGE_W'(1);
    tick     = (state_q == MS_RUN) && (div_q == DIV_W'(HALF_DIV - 1));
    last_tgl = tick && (edge_q == last_idx);
    sample   = tick && (cpha ? phase_q : !phase_q);
  end

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    edge_d  = edge_q;
    phase_d = phase_q;
    case (state_q)
      MS_IDLE: begin
        if (start) begin
          state_d = MS_RUN;
          div_d   = '0;
          edge_d  = '0;
          phase_d = 1'b0;
        end
      end
      default: begin
        if (halt) begin
          state_d = MS_IDLE;
          div_d   = '0;
          edge_d  = '0;
          phase_d = 1'b0;
        end else begin
          div_d = tick ? '0 : div_q + DIV_W'(1);
          if (tick) begin
            phase_d = !phase_q;
            edge_d  = last_tgl ? '0 : edge_q + EDGE_W'(1);
            if (last_tgl && !keep_going) state_d = MS_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      div_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
    end
  end

  assign busy = (state_q == MS_RUN);
  assign sck  = cpol ^ phase_q;

  // R2: an idle master always rests at the idle clock level
  assert_idle_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_IDLE) |-> !phase_q);

  // R3: the toggle counter never runs past the frame's last edge
  assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_RUN) |-> (edge_q <= last_idx));

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter  int MAX_LEN = 16,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample,
  input  logic               din,
  input  logic [LEN_W-1:0]   len,
  output logic               done,
  output logic [MAX_LEN-1:0] word
);

  logic [MAX_LEN-1:0] sh_q, sh_next, mask;
  logic [LEN_W-1:0]   cnt_q;
  logic               at_last;

  always_comb begin
    sh_next = {sh_q[MAX_LEN-2:0], din};
    mask    = {MAX_LEN{1'b1}} >> (MAX_LEN - int'(len));
    at_last = (cnt_q == len - LEN_W'(1));
    done    = sample && at_last;
    word    = sh_next & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sample) begin
      sh_q  <= sh_next;
      cnt_q <= at_last ? '0 : cnt_q + LEN_W'(1);
    end
  end

  // R3: the bit counter stays inside the programmed frame
  assert_cnt_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len);

endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import srx_pkg::*;
#(
  parameter  int HALF_DIV    = 2,
  parameter  int MIN_LEN     = 8,
  parameter  int MAX_LEN     = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int LEN_W       = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_master,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_rx_en,
  input  logic               cfg_stop_one,
  input  logic               cfg_irq_en,
  input  logic [LEN_W-1:0]   cfg_frame_len,
  input  logic               rd_strobe,
  input  logic               ovr_clr,
  output logic [MAX_LEN-1:0] rd_data,
  output logic               rx_ready,
  output logic               rx_overrun,
  output logic               rx_irq,
  output logic               sck_o,
  output logic               cs_n_o,
  input  logic               miso_i,
  input  logic               sck_i,
  input  logic               cs_n_i,
  input  logic               mosi_i
);

  logic [LEN_W-1:0]   len_eff;
  logic               s_cs, s_sck, s_mosi, sck_prev_q;
  logic               slv_active, slv_lead, slv_trail, slv_sample;
  logic               mst_busy, mst_sample, mst_start, mst_sck;
  logic               core_sample, core_din, core_clear, core_done;
  logic [MAX_LEN-1:0] core_word;
  logic               ovr_set, load;
  logic               ready_q, ready_d, ovr_q, ovr_d;
  logic [MAX_LEN-1:0] data_q, data_d;

  assign len_eff = LEN_W'(clamp_len(int'(cfg_frame_len), MIN_LEN, MAX_LEN));

  srx_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n_i, sck_i, mosi_i}),
    .q    ({s_cs, s_sck, s_mosi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= s_sck;
  end

  always_comb begin
    slv_active = !cfg_master && cfg_rx_en && !ovr_q && !s_cs;
    slv_lead   = (sck_prev_q == cfg_cpol) && (s_sck != cfg_cpol);
    slv_trail  = (sck_prev_q != cfg_cpol) && (s_sck == cfg_cpol);
    slv_sample = slv_active && (cfg_cpha ? slv_trail : slv_lead);
  end

  assign mst_start = rd_strobe && cfg_master && cfg_rx_en && !ovr_q;

  srx_clkgen #(
    .HALF_DIV(HALF_DIV),
    .MAX_LEN (MAX_LEN)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mst_start),
    .halt      (ovr_set),
    .keep_going(!cfg_stop_one && cfg_rx_en),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .len       (len_eff),
    .sck       (mst_sck),
    .busy      (mst_busy),
    .sample    (mst_sample)
  );

  always_comb begin
    core_sample = cfg_master ? mst_sample : slv_sample;
    core_din    = cfg_master ? miso_i     : s_mosi;
    core_clear  = cfg_master ? !mst_busy  : !slv_active;
  end

  srx_shift #(
    .MAX_LEN(MAX_LEN)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (core_clear),
    .sample(core_sample),
    .din   (core_din),
    .len   (len_eff),
    .done  (core_done),
    .word  (core_word)
  );

  always_comb begin
    ovr_set = core_done && ready_q && !rd_strobe;
    load    = core_done && !ovr_set;
    ready_d = ready_q;
    if (load)           ready_d = 1'b1;
    else if (rd_strobe) ready_d = 1'b0;
    ovr_d = ovr_q;
    if (ovr_set)      ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
    data_d = load ? core_word : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
      data_q  <= data_d;
    end
  end

  assign rd_data    = data_q;
  assign rx_ready   = ready_q;
  assign rx_overrun = ovr_q;
  assign rx_irq     = cfg_irq_en && (ready_q || ovr_q);
  assign sck_o      = mst_sck;
  assign cs_n_o     = !mst_busy;

  // R4: a completed frame always leaves either fresh data or an error
  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> (ready_q || ovr_q));

  // R5: a read with no frame finishing leaves the ready flag low
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !core_done) |=> !ready_q);

  // R7: the held word is frozen while the overrun error stands
  assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(data_q));

  // R8: no master clock runs while the overrun error stands
  assert_ovr_no_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> !mst_busy);

endmodule

// File: tb/sync_serial_rx_tb_top.sv
module sync_serial_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int MINL       = 8;
  localparam int MAXL       = 16;
  localparam int SLV_HALF   = 4;

  logic        clk, rst_n;
  logic        cfg_master, cfg_cpol, cfg_cpha, cfg_rx_en, cfg_stop_one, cfg_irq_en;
  logic [4:0]  cfg_frame_len;
  logic        rd_strobe, ovr_clr;
  logic [15:0] rd_data;
  logic        rx_ready, rx_overrun, rx_irq, sck_o, cs_n_o;
  logic        miso_i, sck_i, cs_n_i, mosi_i;

  sync_serial_rx #(
    .HALF_DIV(HALF), .MIN_LEN(MINL), .MAX_LEN(MAXL), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rx_en(cfg_rx_en), .cfg_stop_one(cfg_stop_one),
    .cfg_irq_en(cfg_irq_en), .cfg_frame_len(cfg_frame_len), .rd_strobe(rd_strobe),
    .ovr_clr(ovr_clr), .rd_data(rd_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_irq(rx_irq), .sck_o(sck_o), .cs_n_o(cs_n_o),
    .miso_i(miso_i), .sck_i(sck_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // remote transmitter model for master mode: shifts on the non-sampling edge
  logic [63:0] mdl;
  logic        prev_sck;
  assign miso_i = mdl[63];

  always @(negedge clk) begin
    if ((sck_o != prev_sck) && !cs_n_o &&
        (cfg_cpha ? (sck_o != cfg_cpol) : (sck_o == cfg_cpol)))
      mdl <= mdl << 1;
    prev_sck <= sck_o;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
  endtask

  function automatic logic [15:0] lmask(input int len);
    return 16'((32'd1 << len) - 1);
  endfunction

  function automatic logic [63:0] mk_seed(input logic [15:0] a, input logic [15:0] b,
                                          input int len, input logic cpha);
    logic [63:0] s;
    s = (64'(a & lmask(len)) << (64 - len)) | (64'(b & lmask(len)) << (64 - 2*len));
    if (cpha) s = s >> 1;
    return s;
  endfunction

  task automatic wait_ready(input int lim, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_ready) begin hit = 1'b1; break; end
    end
  endtask

  task automatic wait_ovr(input int lim, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_overrun) begin hit = 1'b1; break; end
    end
  endtask

  task automatic clear_ready();
    cfg_rx_en = 1'b0;
    pulse_rd();
    tick(1);
  endtask

  task automatic t_reset();
    cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rx_en = 1'b0;
    cfg_stop_one = 1'b1; cfg_irq_en = 1'b1; cfg_frame_len = 5'd8;
    rd_strobe = 1'b0; ovr_clr = 1'b0;
    sck_i = 1'b0; cs_n_i = 1'b1; mosi_i = 1'b0;
    mdl = '0; prev_sck = 1'b0;
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "flags", {29'd0, rx_ready, rx_overrun, rx_irq}, 32'd0);
    chk("R1", "data", rd_data, 32'd0);
    chk("R1", "cs_n_o/sck_o", {cs_n_o, sck_o}, {1'b1, 1'b0});
  endtask

  // one master frame with stop-after-one; checks data, ready timing and stopping
  task automatic t_master_frame(input logic cpol, input logic cpha, input logic [4:0] lcfg,
                                input int leff, input logic [15:0] d, input string req);
    bit hit;
    cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_frame_len = lcfg;
    cfg_stop_one = 1'b1; cfg_rx_en = 1'b1;
    tick(2);
    chk("R2", "idle clock level", sck_o, cpol);
    mdl = mk_seed(d, 16'h0, leff, cpha);
    pulse_rd();
    tick(1);
    chk("R2", "chip-select active", cs_n_o, 1'b0);
    wait_ready(400, hit);
    chk(req, "ready seen", hit, 1'b1);
    chk("R4", "clock level when ready rises", sck_o, cpha ? cpol : !cpol);
    chk(req, "frame word", rd_data, d & lmask(leff));
    tick(40);
    chk("R6", "stopped after one frame", {cs_n_o, sck_o, rx_overrun}, {1'b1, cpol, 1'b0});
    clear_ready();
    chk("R5", "ready cleared by read", rx_ready, 1'b0);
    chk("R6", "read with rx disabled starts nothing", cs_n_o, 1'b1);
  endtask

  task automatic t_continuous();
    bit hit;
    cfg_master = 1'b1; cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_frame_len = 5'd12;
    cfg_stop_one = 1'b0; cfg_rx_en = 1'b1;
    tick(2);
    mdl = mk_seed(16'h0ABC, 16'h0123, 12, 1'b1);
    pulse_rd();
    wait_ready(400, hit);
    chk("R6", "first streamed word", rd_data, 32'h0ABC);
    pulse_rd();
    cfg_stop_one = 1'b1;
    chk("R6", "clock keeps running between frames", cs_n_o, 1'b0);
    wait_ready(400, hit);
    chk("R6", "second streamed word", rd_data, 32'h0123);
    tick(40);
    chk("R6", "stop request honoured at frame end", {cs_n_o, rx_overrun}, {1'b1, 1'b0});
    clear_ready();
  endtask

  task automatic t_overrun();
    bit hit;
    cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_frame_len = 5'd8;
    cfg_stop_one = 1'b0; cfg_rx_en = 1'b1; cfg_irq_en = 1'b1;
    tick(2);
    mdl = mk_seed(16'h00A5, 16'h003C, 8, 1'b0);
    pulse_rd();
    wait_ready(400, hit);
    chk("R3", "first word before overrun", rd_data, 32'h00A5);
    wait_ovr(400, hit);
    chk("R7", "overrun flag", hit, 1'b1);
    chk("R7", "old word kept", rd_data, 32'h00A5);
    tick(40);
    chk("R7", "clock halted", {cs_n_o, sck_o}, {1'b1, 1'b0});
    pulse_rd();
    chk("R9", "irq from overrun alone", {rx_ready, rx_irq}, {1'b0, 1'b1});
    tick(30);
    chk("R8", "read ignored during overrun", cs_n_o, 1'b1);
    pulse_clr();
    chk("R8", "overrun cleared", rx_overrun, 1'b0);
    cfg_stop_one = 1'b1;
    tick(1);
    mdl = mk_seed(16'h005A, 16'h0, 8, 1'b0);
    pulse_rd();
    wait_ready(400, hit);
    chk("R8", "reception restarts after clear", rd_data, 32'h005A);
    tick(40);
    clear_ready();
  endtask

  task automatic t_irq();
    bit hit;
    cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_frame_len = 5'd8;
    cfg_stop_one = 1'b1; cfg_rx_en = 1'b1; cfg_irq_en = 1'b0;
    tick(2);
    mdl = mk_seed(16'h0071, 16'h0, 8, 1'b1);
    pulse_rd();
    wait_ready(400, hit);
    chk("R9", "irq masked", rx_irq, 1'b0);
    cfg_irq_en = 1'b1;
    tick(1);
    chk("R9", "irq on ready", rx_irq, 1'b1);
    tick(40);
    clear_ready();
    chk("R9", "irq drops with ready", rx_irq, 1'b0);
  endtask

  task automatic slave_frame(input logic cpol, input logic cpha, input int len,
                             input logic [15:0] d);
    cs_n_i = 1'b0;
    tick(SLV_HALF);
    for (int i = len - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = d[i];
        tick(SLV_HALF);
        sck_i = !cpol;
        tick(SLV_HALF);
        sck_i = cpol;
      end else begin
        sck_i = !cpol;
        mosi_i = d[i];
        tick(SLV_HALF);
        sck_i = cpol;
        tick(SLV_HALF);
      end
    end
    tick(6);
    cs_n_i = 1'b1;
    tick(6);
  endtask

  task automatic t_slave();
    cfg_master = 1'b0; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_frame_len = 5'd10;
    cfg_rx_en = 1'b1; cfg_irq_en = 1'b0;
    sck_i = 1'b1; cs_n_i = 1'b1;
    tick(6);
    slave_frame(1'b1, 1'b0, 10, 16'h02C7);
    chk("R10", "slave word mode 2", {rx_ready, 15'd0, rd_data}, {1'b1, 15'd0, 16'h02C7});
    pulse_rd();
    // edges with chip-select high
    for (int i = 0; i < 12; i++) begin
      sck_i = 1'b0; tick(SLV_HALF); sck_i = 1'b1; tick(SLV_HALF);
    end
    tick(6);
    chk("R10", "edges ignored while deselected", rx_ready, 1'b0);
    // partial frame then a full one in mode 1
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_frame_len = 5'd8; sck_i = 1'b0;
    tick(6);
    slave_frame(1'b0, 1'b1, 3, 16'h0007);
    chk("R10", "partial frame discarded", rx_ready, 1'b0);
    slave_frame(1'b0, 1'b1, 8, 16'h0096);
    chk("R10", "slave word mode 1", rd_data, 32'h0096);
    // second frame unread -> overrun, third frame ignored
    slave_frame(1'b0, 1'b1, 8, 16'h0011);
    chk("R7", "slave overrun", {rx_overrun, 15'd0, rd_data}, {1'b1, 15'd0, 16'h0096});
    pulse_rd();
    slave_frame(1'b0, 1'b1, 8, 16'h0022);
    chk("R8", "slave frame ignored during overrun", {rx_ready, 15'd0, rd_data},
        {1'b0, 15'd0, 16'h0096});
    pulse_clr();
    slave_frame(1'b0, 1'b1, 8, 16'h0033);
    chk("R8", "slave resumes after clear", {rx_ready, 15'd0, rd_data}, {1'b1, 15'd0, 16'h0033});
    pulse_rd();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_master_frame(1'b0, 1'b0, 5'd8,  8,  16'h00B4, "R3");
    t_master_frame(1'b1, 1'b0, 5'd16, 16, 16'hC35A, "R3");
    t_master_frame(1'b0, 1'b1, 5'd13, 13, 16'h1A2B, "R4");
    t_master_frame(1'b1, 1'b1, 5'd5,  8,  16'h00C3, "R3");
    t_master_frame(1'b0, 1'b0, 5'd31, 16, 16'h8001, "R3");
    t_continuous();
    t_overrun();
    t_irq();
    t_slave();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule